// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block gathers three interrupt sources for a small 8-bit processor core and turns them into the signals the core and its sleep logic need. The sources are a level on an external pin whose active edge software can pick, the wrap of an 8-bit timer from all ones to zero, and any change on a four-bit slice of an input port. Every source owns a sticky flag and an enable bit. These sit together with a global enable in one 8-bit control register that software reads and writes as a whole.

The block drives three outputs. The first is an interrupt request to the running core. The second is a wake-up request to the sleep logic, which depends only on flags and their individual enables. The third tells the core, as it wakes, whether to jump to the interrupt vector or carry on with the next instruction. When the core accepts an interrupt, the global enable drops. A return strobe raises it again. The pin and the port are sampled through a two-flop synchroniser before edge and change detection, and nothing is detected until the synchroniser and the comparison copy hold real samples.

Control register layout (bit: meaning): 7 global enable, 6 reserved, 5 timer enable, 4 pin enable, 3 port enable, 2 timer flag, 1 pin flag, 0 port flag.

Top module: `intr_flag_ctrl`

## Requirements
- R1: With `ext_rise_sel` = 1, a 0-to-1 change on `ext_pin` sets control bit 1 on the third rising clock edge after the change, and a 1-to-0 change sets nothing.
- R2: With `ext_rise_sel` = 0, a 1-to-0 change on `ext_pin` sets control bit 1, and a 0-to-1 change sets nothing.
- R3: `tmr_count` moving from 8'hFF to 8'h00 between two clock edges sets control bit 2 on the next edge. A move to 8'h00 from any other value sets nothing.
- R4: A change on any single bit of `port_hi` sets control bit 0, with the same latency as R1.
- R5: Flags are sticky. A write of 0 to a flag bit clears it, a write of 1 sets it, and a flag holds its value while no write occurs.
- R6: When a hardware event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_req` is high exactly when bit 7 is 1 and some flag is 1 together with its enable (bit 2 with 5, bit 1 with 4, bit 0 with 3).
- R8: `wake_req` is high exactly when `core_asleep` is 1 and some flag is 1 together with its enable, whatever bit 7 holds.
- R9: `wake_vector` is high exactly when `wake_req` is high and bit 7 is 1.
- R10: `irq_accept` clears bit 7 on the next edge. Otherwise `irq_return` sets it. Otherwise a register write loads it. `irq_accept` wins over both.
- R11: Levels on `ext_pin` and `port_hi` that are present through reset set no flag. Detection starts on the fourth edge after reset release.
- R12: Bit 6 always reads 0. After reset the whole register reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_rise_sel | input | 1 | 1 selects rising edges on the pin, 0 selects falling edges |
| port_hi | input | PORT_W | Asynchronous port bits watched for change |
| tmr_count | input | TMR_W | Current timer register value |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Write data for the control register |
| ctl_rd_data | output | 8 | Current control register contents |
| core_asleep | input | 1 | Core is in sleep mode |
| irq_accept | input | 1 | Core takes the interrupt this cycle |
| irq_return | input | 1 | Core returns from the interrupt routine |
| irq_req | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake-up request to the sleep logic |
| wake_vector | output | 1 | Branch to the vector after wake-up |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a four-bit port slice and an 8-bit timer. Because the timer value is a plain input, the bench can present the 8'hFF to 8'h00 wrap and near-miss values such as 8'h05 to 8'h00 directly, without counting through 256 steps. The two-stage setting places pin and port detection exactly three edges after a change. That makes it possible to land a software clear in the same cycle as a hardware set, and to check that no flag appears during the startup window.

// File: rtl/ifc_pkg.sv
// Package: shared layout of the interrupt control register.
// Assumes three sources, ordered timer / pin / port from high to low.
package ifc_pkg;
    localparam int NUM_SRC = 3;
    localparam int CTL_W   = 8;

    // Source index within the flag and enable fields.
    typedef enum int unsigned {
        SRC_PORT = 0,
        SRC_EXT  = 1,
        SRC_TMR  = 2
    } src_e;

    // Register image: bit 7 global enable, bit 6 reserved,
    // bits 5:3 enables, bits 2:0 flags.
    typedef struct packed {
        logic               gie;
        logic               rsv;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] flag;
    } ctl_reg_t;
endpackage

// File: rtl/ifc_sync_arm.sv
// Module: multi-stage synchroniser with a copy of the previous synced
// value and an arm signal that rises once that copy holds a real sample.
// Assumes STAGES >= 2 and a synchronous active-low reset.
module ifc_sync_arm #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_q,
    output logic [WIDTH-1:0] prev_q,
    output logic             armed
);
    localparam int ARM_CNT = STAGES + 1;
    localparam int CW      = $clog2(ARM_CNT + 1);

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [CW-1:0]                arm_cnt;

    // Shift the raw input through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Keep the previous synchronised value for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    // Count edges since reset until the comparison copy is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                      arm_cnt <= '0;
        else if (arm_cnt != CW'(ARM_CNT)) arm_cnt <= arm_cnt + 1'b1;
    end

    assign sync_q = chain[STAGES-1];
    assign armed  = (arm_cnt == CW'(ARM_CNT));

    // Once armed, detection stays enabled until the next reset.
    p_arm_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

// File: rtl/ifc_event_detect.sv
// Module: turns the pin, the port slice and the timer value into one-cycle
// event pulses, one per source. Assumes the timer is in the clock domain,
// while the pin and the port are asynchronous.
module ifc_event_detect
    import ifc_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pin,
    input  logic               rise_sel,
    input  logic [PORT_W-1:0]  port_in,
    input  logic [TMR_W-1:0]   tmr_val,
    output logic [NUM_SRC-1:0] evt
);
    logic              ext_cur, ext_prev, ext_armed;
    logic [PORT_W-1:0] port_cur, port_prev, bit_chg;
    logic              port_armed;
    logic [TMR_W-1:0]  tmr_prev;

    ifc_sync_arm #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_pin),
        .sync_q(ext_cur), .prev_q(ext_prev), .armed(ext_armed)
    );

    ifc_sync_arm #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .async_in(port_in),
        .sync_q(port_cur), .prev_q(port_prev), .armed(port_armed)
    );

    // Per-bit change detection on the port slice.
    for (genvar g = 0; g < PORT_W; g++) begin : g_chg
        assign bit_chg[g] = port_cur[g] ^ port_prev[g];
    end

    // Remember the last timer value to spot the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_prev <= '0;
        else        tmr_prev <= tmr_val;
    end

    // Combine the detections into per-source pulses.
    always_comb begin
        evt           = '0;
        evt[SRC_EXT]  = ext_armed & (rise_sel ? (ext_cur & ~ext_prev)
                                              : (~ext_cur & ext_prev));
        evt[SRC_PORT] = port_armed & (|bit_chg);
        evt[SRC_TMR]  = (tmr_prev == '1) && (tmr_val == '0);
    end

    // A pin event needs the armed synchroniser.
    p_ext_needs_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt[SRC_EXT] |-> (ext_armed && (ext_cur != ext_prev)));
endmodule

// File: rtl/ifc_flag_bank.sv
// Module: control register with sticky flags, enables and the global
// enable. A hardware set beats a software clear in the same cycle.
// Assumes one-cycle hw_set pulses and single-cycle write strobes.
module ifc_flag_bank
    import ifc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_set,
    input  logic               wr_en,
    input  ctl_reg_t           wr_data,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output ctl_reg_t           ctl_q
);
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic               gie_q;

    // One sticky flag per source; hardware set has priority.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[s] <= 1'b0;
            else if (hw_set[s])  flag_q[s] <= 1'b1;
            else if (wr_en)      flag_q[s] <= wr_data.flag[s];
        end

        p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[s] && !wr_en) |=> flag_q[s]);
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[s] |=> flag_q[s]);
    end

    // Enables load only from software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_data.en;
    end

    // Global enable: accept clears, return sets, then the write.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (irq_ack)  gie_q <= 1'b0;
        else if (irq_ret)  gie_q <= 1'b1;
        else if (wr_en)    gie_q <= wr_data.gie;
    end

    // Assemble the visible register image.
    always_comb begin
        ctl_q      = '0;
        ctl_q.gie  = gie_q;
        ctl_q.en   = en_q;
        ctl_q.flag = flag_q;
    end

    p_accept_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie_q);
    p_return_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> gie_q);
endmodule

// File: rtl/intr_flag_ctrl.sv
// Module: top of the interrupt flag and wake controller. Joins the event
// detector and the control register and forms the request outputs.
// Assumes the core samples irq_req and the sleep logic samples
// wake_req / wake_vector in the clock domain of clk.
module intr_flag_ctrl
    import ifc_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int TMR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              ext_rise_sel,
    input  logic [PORT_W-1:0] port_hi,
    input  logic [TMR_W-1:0]  tmr_count,
    input  logic              ctl_wr_en,
    input  logic [7:0]        ctl_wr_data,
    output logic [7:0]        ctl_rd_data,
    input  logic              core_asleep,
    input  logic              irq_accept,
    input  logic              irq_return,
    output logic              irq_req,
    output logic              wake_req,
    output logic              wake_vector
);
    logic [NUM_SRC-1:0] src_evt;
    ctl_reg_t           wr_img;
    ctl_reg_t           ctl_q;
    logic               pending;
    logic               unused_rsv;

    ifc_event_detect #(
        .PORT_W(PORT_W), .TMR_W(TMR_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .rise_sel(ext_rise_sel),
        .port_in(port_hi), .tmr_val(tmr_count), .evt(src_evt)
    );

    assign wr_img     = ctl_reg_t'(ctl_wr_data);
    assign unused_rsv = wr_img.rsv;

    ifc_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .hw_set(src_evt), .wr_en(ctl_wr_en),
        .wr_data(wr_img), .irq_ack(irq_accept), .irq_ret(irq_return),
        .ctl_q(ctl_q)
    );

    // Request outputs from the register image.
    always_comb begin
        pending     = |(ctl_q.flag & ctl_q.en);
        irq_req     = ctl_q.gie & pending;
        wake_req    = core_asleep & pending;
        wake_vector = wake_req & ctl_q.gie;
        ctl_rd_data = CTL_W'(ctl_q);
    end

    p_ext_event_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[SRC_EXT] |=> ctl_rd_data[1]);
    p_tmr_event_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt[SRC_TMR] |=> ctl_rd_data[2]);
    p_irq_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctl_rd_data[7]);
    p_wake_ignores_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_asleep && ctl_rd_data[1] && ctl_rd_data[4]) |-> wake_req);
    p_vector_needs_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_vector |-> (wake_req && ctl_rd_data[7]));
endmodule

// File: tb/intr_flag_ctrl_bench.sv
// Bench: behavioural per-edge model with sample history, compared on every
// clock, plus directed checks per requirement.
module intr_flag_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b1;
    logic       ext_rise_sel = 1'b1;
    logic [3:0] port_hi = 4'hA;
    logic [7:0] tmr_count = 8'h00;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = 8'h00;
    logic [7:0] ctl_rd_data;
    logic       core_asleep = 1'b0;
    logic       irq_accept = 1'b0;
    logic       irq_return = 1'b0;
    logic       irq_req, wake_req, wake_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    intr_flag_ctrl u_intr_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel),
        .port_hi(port_hi), .tmr_count(tmr_count), .ctl_wr_en(ctl_wr_en),
        .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .core_asleep(core_asleep), .irq_accept(irq_accept),
        .irq_return(irq_return), .irq_req(irq_req), .wake_req(wake_req),
        .wake_vector(wake_vector)
    );

    // ---------------- reference model ----------------
    int       n_edges = 0;
    bit       pin_h[3];
    bit [3:0] port_h[3];
    bit [7:0] tmr_last = 8'h00;
    bit       m_gie = 1'b0;
    bit [2:0] m_en = 3'b000;
    bit [2:0] m_flag = 3'b000;

    always @(posedge clk) begin
        bit [2:0] set;
        set = 3'b000;
        if (!rst_n) begin
            n_edges = 0; tmr_last = 8'h00;
            m_gie = 1'b0; m_en = 3'b000; m_flag = 3'b000;
        end else begin
            n_edges++;
            if (n_edges >= 4) begin
                if (ext_rise_sel ? (pin_h[1] && !pin_h[2]) : (!pin_h[1] && pin_h[2]))
                    set[1] = 1'b1;
                if (port_h[1] != port_h[2]) set[0] = 1'b1;
            end
            if (tmr_last == 8'hFF && tmr_count == 8'h00) set[2] = 1'b1;
            tmr_last = tmr_count;
            if (ctl_wr_en) begin
                m_en = ctl_wr_data[5:3];
                m_flag = ctl_wr_data[2:0];
            end
            m_flag = m_flag | set;
            if (irq_accept)      m_gie = 1'b0;
            else if (irq_return) m_gie = 1'b1;
            else if (ctl_wr_en)  m_gie = ctl_wr_data[7];
        end
        pin_h[2] = pin_h[1]; pin_h[1] = pin_h[0]; pin_h[0] = ext_pin;
        port_h[2] = port_h[1]; port_h[1] = port_h[0]; port_h[0] = port_hi;
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model shortly after each edge.
    always @(posedge clk) begin
        bit pend;
        #1;
        if (rst_n && !done) begin
            pend = |(m_flag & m_en);
            chk("R12", "model rd", ctl_rd_data, {m_gie, 1'b0, m_en, m_flag});
            chk("R7", "model irq", {7'b0, irq_req}, {7'b0, m_gie & pend});
            chk("R8", "model wake", {7'b0, wake_req}, {7'b0, core_asleep & pend});
            chk("R9", "model vec", {7'b0, wake_vector},
                {7'b0, core_asleep & pend & m_gie});
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic steps(int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic wr_ctl(logic [7:0] d);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        step();
        ctl_wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        steps(3);
        rst_n = 1'b1;
        step();
        chk("R12", "reset value", ctl_rd_data, 8'h00);
        steps(6);
        chk("R11", "startup levels ignored", ctl_rd_data, 8'h00);

        // R1: rising selected, falling ignored, latency of three edges
        ext_pin = 1'b0;
        steps(5);
        chk("R1", "falling ignored", {7'b0, ctl_rd_data[1]}, 8'h00);
        ext_pin = 1'b1;
        steps(2);
        chk("R11", "not yet after two edges", {7'b0, ctl_rd_data[1]}, 8'h00);
        step();
        chk("R1", "rising sets flag", {7'b0, ctl_rd_data[1]}, 8'h01);
        wr_ctl(8'h00);
        chk("R5", "write 0 clears", ctl_rd_data, 8'h00);
        wr_ctl(8'h07);
        chk("R5", "write 1 sets", ctl_rd_data, 8'h07);
        steps(3);
        chk("R5", "flags hold", ctl_rd_data, 8'h07);
        wr_ctl(8'h00);

        // R2: falling selected
        ext_rise_sel = 1'b0;
        ext_pin = 1'b0;
        steps(4);
        chk("R2", "falling sets flag", {7'b0, ctl_rd_data[1]}, 8'h01);
        wr_ctl(8'h00);
        ext_pin = 1'b1;
        steps(4);
        chk("R2", "rising ignored", {7'b0, ctl_rd_data[1]}, 8'h00);

        // R3: timer wrap
        tmr_count = 8'hFE; step();
        tmr_count = 8'hFF; step();
        tmr_count = 8'h00; step();
        chk("R3", "wrap sets flag", {7'b0, ctl_rd_data[2]}, 8'h01);
        wr_ctl(8'h00);
        tmr_count = 8'h05; step();
        tmr_count = 8'h00; steps(2);
        chk("R3", "non-wrap ignored", {7'b0, ctl_rd_data[2]}, 8'h00);

        // R4: each port bit on its own
        for (int b = 0; b < 4; b++) begin
            port_hi[b] = ~port_hi[b];
            steps(4);
            chk("R4", $sformatf("port bit %0d", b), {7'b0, ctl_rd_data[0]}, 8'h01);
            wr_ctl(8'h00);
        end

        // R6: hardware set lands together with a software clear
        port_hi[0] = ~port_hi[0];
        steps(2);
        wr_ctl(8'h00);
        chk("R6", "set beats clear", {7'b0, ctl_rd_data[0]}, 8'h01);
        wr_ctl(8'h00);

        // R7 and R12: masking and layout
        wr_ctl(8'h3A);
        chk("R7", "no gie no irq", {7'b0, irq_req}, 8'h00);
        wr_ctl(8'hBA);
        chk("R7", "gie and enabled flag", {7'b0, irq_req}, 8'h01);
        wr_ctl(8'hAA);
        chk("R7", "flag without enable", {7'b0, irq_req}, 8'h00);
        wr_ctl(8'hFF);
        chk("R12", "bit 6 reads 0", ctl_rd_data, 8'hBF);
        wr_ctl(8'h00);

        // R8 / R9: wake-up and vector choice
        core_asleep = 1'b1;
        wr_ctl(8'h12);
        chk("R8", "wake without gie", {7'b0, wake_req}, 8'h01);
        chk("R9", "no vector without gie", {7'b0, wake_vector}, 8'h00);
        chk("R7", "no irq without gie", {7'b0, irq_req}, 8'h00);
        wr_ctl(8'h92);
        chk("R9", "vector with gie", {7'b0, wake_vector}, 8'h01);
        core_asleep = 1'b0;
        step();
        chk("R8", "awake no wake", {7'b0, wake_req}, 8'h00);
        chk("R7", "awake irq", {7'b0, irq_req}, 8'h01);

        // R10: global enable control
        irq_accept = 1'b1; step(); irq_accept = 1'b0;
        chk("R10", "accept clears gie", {7'b0, ctl_rd_data[7]}, 8'h00);
        chk("R10", "accept drops irq", {7'b0, irq_req}, 8'h00);
        irq_return = 1'b1; step(); irq_return = 1'b0;
        chk("R10", "return sets gie", {7'b0, ctl_rd_data[7]}, 8'h01);
        irq_accept = 1'b1; irq_return = 1'b1; step();
        irq_accept = 1'b0; irq_return = 1'b0;
        chk("R10", "accept beats return", {7'b0, ctl_rd_data[7]}, 8'h00);
        irq_accept = 1'b1; wr_ctl(8'h92); irq_accept = 1'b0;
        chk("R10", "accept beats write", {7'b0, ctl_rd_data[7]}, 8'h00);
        wr_ctl(8'h00);
        steps(2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule